// File: doc/BRIEF.md
# Video Clock Source Sequencer

This block decides which clock drives the video clock pin. There are six candidate sources: three synthesized clocks (VCO0..VCO2), an external clock, the reference clock and the memory clock. Frequency synthesis is not part of the block, so every source arrives as an input.

The two select pins and the active-low external-route pin are first synchronized into the memory-clock domain. They are then debounced by a first timeout before they are decoded. This gives a pin wiggle that begins a serial programming burst time to be recognised as such, instead of being taken as a register choice. When the decoded choice is a synthesized clock, or when software rewrites the register that feeds the live video clock, a settling interval follows. During that interval a fallback clock (reference or memory) drives the output while the new VCO frequency settles. Both timeouts are counted in memory-clock cycles, and a control input doubles them.

Every change of source passes through a glitch-free gate cell per source. The old gate closes on its own source's falling edge. The new gate opens on its own falling edge, and only after the closure has been handshaken back through synchronizers. The sequencer is a seven-state machine:
- IDLE: steady. The selected source drives the output.
- DEBOUNCE: the first timeout is running.
- FB_DROP: waiting for the old gate to close before the fallback.
- FB_RAISE: waiting for the fallback gate to open.
- SETTLE: the second timeout is running on the fallback.
- SEL_DROP: waiting for the current gate to close before the final source.
- SEL_RAISE: waiting for the final source's gate to open, then back to IDLE.

Transitions:
- IDLE→DEBOUNCE when the synchronized pin code changes.
- IDLE→FB_DROP on a hitting register rewrite.
- DEBOUNCE→IDLE, FB_DROP or SEL_DROP at the end of the timeout.
- FB_DROP→FB_RAISE when all gates are closed.
- FB_RAISE→SETTLE when the fallback gate acknowledges.
- SETTLE→SEL_DROP at the end of the settling interval.
- SEL_DROP→SEL_RAISE when all gates are closed.
- SEL_RAISE→IDLE when the final gate acknowledges.

Top module: `vclk_source_seq`

## Requirements
- R1: After reset the sequencer assumes pin code {ext_route_n,sel1,sel0}=100 and opens the VCO0 gate, so `vclk_out` follows `vco_clk[0]` with no timeout.
- R2: The debounced pin code decodes as follows. sel1,sel0=00 selects VCO0 and 01 selects VCO1. 11 selects VCO2. 10 selects the external clock when ext_route_n=0 and VCO2 when ext_route_n=1.
- R3: A pin change takes effect only after FIRST_TIMEOUT memory-clock cycles (after a two-cycle synchronizer) with the pins stable, and the previous source keeps driving until then. Any pin change during that timeout restarts it.
- R4: When the decoded choice is a VCO, the fallback clock drives the output for SETTLE_TIMEOUT memory-clock cycles, and then the chosen VCO drives it.
- R5: `fb_use_mem`=0 picks the reference clock as fallback and 1 picks the memory clock. It is sampled when the fallback gate is about to open.
- R6: `tmo_double`=1 makes both timeouts twice as long as with 0.
- R7: A choice of the external clock switches to it directly, with no fallback and no settling interval.
- R8: While steady on a VCO, a `reg_wr` pulse whose `reg_wr_addr` is the active VCO index (0..2) or the memory register (3) starts the fallback-then-settle sequence. A pulse naming another VCO index has no effect on the output.
- R9: A hitting rewrite during the settling interval restarts the settling count.
- R10: When the debounced code decodes to the source already driving (pins returned, or a bit that does not change the decode), no switch happens.
- R11: At most one gate is open at any time, and `vclk_out` carries no pulse shorter than the shortest half period among the sources.
- R12: `pwr_dn_n`=0 forces `vclk_out` high. `vclk_drive_en` follows `out_en`, so a low value marks the pin as tristated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_clk | input | 1 | Memory clock; clocks the sequencer and the timeouts, and is also a source |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock source |
| ext_clk | input | 1 | External clock source |
| vco_clk | input | 3 | Synthesized clock sources VCO0..VCO2 |
| sel0_pin | input | 1 | Select pin 0 (asynchronous) |
| sel1_pin | input | 1 | Select pin 1 (asynchronous) |
| ext_route_n | input | 1 | Active-low external-clock routing pin |
| out_en | input | 1 | Output enable |
| pwr_dn_n | input | 1 | Active-low power-down |
| tmo_double | input | 1 | Doubles both timeouts |
| fb_use_mem | input | 1 | Fallback choice: 0 reference, 1 memory clock |
| reg_wr | input | 1 | One-cycle register-rewrite notification |
| reg_wr_addr | input | 3 | Rewritten register: 0..2 VCO, 3 memory |
| vclk_out | output | 1 | Video clock |
| vclk_drive_en | output | 1 | Drive enable of the video clock pin |

## Verification
Assertions check several properties on every memory-clock cycle. At most one gate acknowledge is ever high. The debounce and settle states are left only once their counters have reached the active limit. A live fallback gate exists throughout SETTLE, and SETTLE is never entered on the way to the external clock. Other behaviours need whole scenarios from the bench:
- the decode of each pin code and the held old clock;
- the debounce restart and the no-switch cases;
- the fallback choice and the doubled intervals;
- the rewrite filtering and the settle restart;
- the absence of runt pulses across every switch.

The bench checks these by comparing `vclk_out` sample by sample against the clock it should be following.

// File: rtl/vclk_seq_pkg.sv
package vclk_seq_pkg;

    localparam int NUM_VCO = 3;
    localparam int NUM_SRC = NUM_VCO + 3;
    localparam int PIN_W   = 3;

    // Source indices; gate cells are laid out in this order.
    typedef enum logic [2:0] {
        SRC_VCO0 = 3'd0,
        SRC_VCO1 = 3'd1,
        SRC_VCO2 = 3'd2,
        SRC_EXT  = 3'd3,
        SRC_REF  = 3'd4,
        SRC_MEM  = 3'd5
    } src_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEBOUNCE,
        ST_FB_DROP,
        ST_FB_RAISE,
        ST_SETTLE,
        ST_SEL_DROP,
        ST_SEL_RAISE
    } state_e;

    localparam logic [2:0] MEM_REG_ADDR = 3'd3;
    localparam logic [PIN_W-1:0] PIN_RESET_CODE = 3'b100;

    // code = {ext_route_n, sel1, sel0}
    function automatic src_e decode_pins(input logic [PIN_W-1:0] code);
        src_e s;
        unique case (code[1:0])
            2'b00:   s = SRC_VCO0;
            2'b01:   s = SRC_VCO1;
            2'b10:   s = code[2] ? SRC_VCO2 : SRC_EXT;
            default: s = SRC_VCO2;
        endcase
        return s;
    endfunction

    function automatic logic [NUM_SRC-1:0] src_onehot(input src_e s);
        logic [NUM_SRC-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

    function automatic logic is_vco(input src_e s);
        return (s == SRC_VCO0) || (s == SRC_VCO1) || (s == SRC_VCO2);
    endfunction

endpackage

// File: rtl/vclk_pin_sync.sv
module vclk_pin_sync #(
    parameter int              WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= RST_VAL;
            sync_out <= RST_VAL;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end

endmodule

// File: rtl/vclk_gate_cell.sv
module vclk_gate_cell (
    input  logic src_clk,
    input  logic sys_clk,
    input  logic rst_n,
    input  logic req,
    output logic gated_clk,
    output logic ack
);

    logic en_meta_q, en_q;
    logic ack_meta_q;

    // Enable moves only on the source's falling edge, while the source is low.
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            en_meta_q <= 1'b0;
            en_q      <= 1'b0;
        end else begin
            en_meta_q <= req;
            en_q      <= en_meta_q;
        end
    end

    // Gate state handed back to the sequencer domain.
    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_meta_q <= 1'b0;
            ack        <= 1'b0;
        end else begin
            ack_meta_q <= en_q;
            ack        <= ack_meta_q;
        end
    end

    assign gated_clk = src_clk & en_q;

endmodule

// File: rtl/vclk_seq_fsm.sv
module vclk_seq_fsm
    import vclk_seq_pkg::*;
#(
    parameter int FIRST_TO  = 2000,
    parameter int SETTLE_TO = 20000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PIN_W-1:0]   pin_code,
    input  logic               tmo_double,
    input  logic               fb_use_mem,
    input  logic               reg_wr,
    input  logic [2:0]         reg_wr_addr,
    input  logic [NUM_SRC-1:0] ack_vec,
    output logic [NUM_SRC-1:0] req_vec
);

    localparam int MAX_TO = (FIRST_TO > SETTLE_TO) ? FIRST_TO : SETTLE_TO;
    localparam int CW     = $clog2(2 * MAX_TO + 1);
    localparam logic [CW-1:0] LIM1_N = CW'(FIRST_TO - 1);
    localparam logic [CW-1:0] LIM1_L = CW'(2 * FIRST_TO - 1);
    localparam logic [CW-1:0] LIM2_N = CW'(SETTLE_TO - 1);
    localparam logic [CW-1:0] LIM2_L = CW'(2 * SETTLE_TO - 1);

    state_e            state_q, state_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [PIN_W-1:0]  code_q, code_d;
    src_e              cur_q, cur_d;
    src_e              goal_q, goal_d;
    logic [CW-1:0]     lim_first, lim_settle;
    src_e              decoded;
    logic              hit_cur, hit_goal;

    function automatic logic rewrite_hits(input src_e s, input logic wr,
                                          input logic [2:0] addr);
        return is_vco(s) && wr && ((addr == MEM_REG_ADDR) || (addr == 3'(s)));
    endfunction

    assign lim_first  = tmo_double ? LIM1_L : LIM1_N;
    assign lim_settle = tmo_double ? LIM2_L : LIM2_N;
    assign decoded    = decode_pins(code_q);
    assign hit_cur    = rewrite_hits(cur_q, reg_wr, reg_wr_addr);
    assign hit_goal   = rewrite_hits(goal_q, reg_wr, reg_wr_addr);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        code_d  = code_q;
        cur_d   = cur_q;
        goal_d  = goal_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pin_code != code_q) begin
                    code_d  = pin_code;
                    cnt_d   = '0;
                    state_d = ST_DEBOUNCE;
                end else if (hit_cur) begin
                    goal_d  = cur_q;
                    state_d = ST_FB_DROP;
                end
            end
            ST_DEBOUNCE: begin
                if (pin_code != code_q) begin
                    code_d = pin_code;
                    cnt_d  = '0;
                end else if (cnt_q >= lim_first) begin
                    if (decoded == cur_q) begin
                        state_d = ST_IDLE;
                    end else begin
                        goal_d  = decoded;
                        state_d = is_vco(decoded) ? ST_FB_DROP : ST_SEL_DROP;
                    end
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_FB_DROP: begin
                if (ack_vec == '0) begin
                    cur_d   = fb_use_mem ? SRC_MEM : SRC_REF;
                    state_d = ST_FB_RAISE;
                end
            end
            ST_FB_RAISE: begin
                if (ack_vec[cur_q]) begin
                    cnt_d   = '0;
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (hit_goal) begin
                    cnt_d = '0;
                end else if (cnt_q >= lim_settle) begin
                    state_d = ST_SEL_DROP;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_SEL_DROP: begin
                if (ack_vec == '0) begin
                    cur_d   = goal_q;
                    state_d = ST_SEL_RAISE;
                end
            end
            ST_SEL_RAISE: begin
                if (ack_vec[cur_q]) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEL_RAISE;
            cnt_q   <= '0;
            code_q  <= PIN_RESET_CODE;
            cur_q   <= SRC_VCO0;
            goal_q  <= SRC_VCO0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            code_q  <= code_d;
            cur_q   <= cur_d;
            goal_q  <= goal_d;
        end
    end

    always_comb begin
        if (state_q == ST_FB_DROP || state_q == ST_SEL_DROP) begin
            req_vec = '0;
        end else begin
            req_vec = src_onehot(cur_q);
        end
    end

    assert_debounce_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_DEBOUNCE && state_q != ST_DEBOUNCE)
        |-> ($past(cnt_q) >= $past(lim_first)));

    assert_settle_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SETTLE && state_q != ST_SETTLE)
        |-> ($past(cnt_q) >= $past(lim_settle)));

    assert_fallback_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> (ack_vec[SRC_REF] || ack_vec[SRC_MEM]));

    assert_ext_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> (goal_q != SRC_EXT));

endmodule

// File: rtl/vclk_source_seq.sv
module vclk_source_seq
    import vclk_seq_pkg::*;
#(
    parameter int FIRST_TIMEOUT  = 2000,
    parameter int SETTLE_TIMEOUT = 20000
) (
    input  logic               mem_clk,
    input  logic               rst_n,
    input  logic               ref_clk,
    input  logic               ext_clk,
    input  logic [NUM_VCO-1:0] vco_clk,
    input  logic               sel0_pin,
    input  logic               sel1_pin,
    input  logic               ext_route_n,
    input  logic               out_en,
    input  logic               pwr_dn_n,
    input  logic               tmo_double,
    input  logic               fb_use_mem,
    input  logic               reg_wr,
    input  logic [2:0]         reg_wr_addr,
    output logic               vclk_out,
    output logic               vclk_drive_en
);

    logic [PIN_W-1:0]   pin_code;
    logic [NUM_SRC-1:0] src_clks;
    logic [NUM_SRC-1:0] req_vec, ack_vec, gated;

    assign src_clks = {mem_clk, ref_clk, ext_clk, vco_clk};

    vclk_pin_sync #(.WIDTH(PIN_W), .RST_VAL(PIN_RESET_CODE)) u_pin_sync (
        .clk      (mem_clk),
        .rst_n    (rst_n),
        .async_in ({ext_route_n, sel1_pin, sel0_pin}),
        .sync_out (pin_code)
    );

    vclk_seq_fsm #(.FIRST_TO(FIRST_TIMEOUT), .SETTLE_TO(SETTLE_TIMEOUT)) u_fsm (
        .clk         (mem_clk),
        .rst_n       (rst_n),
        .pin_code    (pin_code),
        .tmo_double  (tmo_double),
        .fb_use_mem  (fb_use_mem),
        .reg_wr      (reg_wr),
        .reg_wr_addr (reg_wr_addr),
        .ack_vec     (ack_vec),
        .req_vec     (req_vec)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
        vclk_gate_cell u_gate (
            .src_clk   (src_clks[g]),
            .sys_clk   (mem_clk),
            .rst_n     (rst_n),
            .req       (req_vec[g]),
            .gated_clk (gated[g]),
            .ack       (ack_vec[g])
        );
    end

    always_comb begin
        vclk_out      = (!pwr_dn_n) ? 1'b1 : (|gated);
        vclk_drive_en = out_en;
    end

    assert_single_source_R11: assert property (@(posedge mem_clk) disable iff (!rst_n)
        $onehot0(ack_vec));

endmodule

// File: tb/vclk_source_seq_tb_top.sv
`timescale 1ns/100ps
module vclk_source_seq_tb_top;

    localparam int T1 = 60;
    localparam int T2 = 120;

    logic mem_clk = 1'b0, ref_clk = 1'b0, ext_clk = 1'b0;
    logic [2:0] vco_clk = 3'b000;
    logic rst_n = 1'b0;
    logic sel0_pin = 1'b0, sel1_pin = 1'b0, ext_route_n = 1'b1;
    logic out_en = 1'b1, pwr_dn_n = 1'b1, tmo_double = 1'b0, fb_use_mem = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_wr_addr = 3'd0;
    logic vclk_out, vclk_drive_en;

    int checks = 0, errors = 0, cyc = 0, mark_cyc = 0, runts = 0;
    bit done = 1'b0, mon_en = 1'b0, have_last = 1'b0;
    realtime last_edge = 0.0;

    always #2  mem_clk    = ~mem_clk;
    always #3  vco_clk[0] = ~vco_clk[0];
    always #7  vco_clk[1] = ~vco_clk[1];
    always #9  vco_clk[2] = ~vco_clk[2];
    always #11 ext_clk    = ~ext_clk;
    always #5  ref_clk    = ~ref_clk;
    always @(negedge mem_clk) cyc <= cyc + 1;

    vclk_source_seq #(.FIRST_TIMEOUT(T1), .SETTLE_TIMEOUT(T2)) dut_i (
        .mem_clk(mem_clk), .rst_n(rst_n), .ref_clk(ref_clk), .ext_clk(ext_clk),
        .vco_clk(vco_clk), .sel0_pin(sel0_pin), .sel1_pin(sel1_pin),
        .ext_route_n(ext_route_n), .out_en(out_en), .pwr_dn_n(pwr_dn_n),
        .tmo_double(tmo_double), .fb_use_mem(fb_use_mem), .reg_wr(reg_wr),
        .reg_wr_addr(reg_wr_addr), .vclk_out(vclk_out), .vclk_drive_en(vclk_drive_en)
    );

    // R11: runt pulse monitor (shortest source half period is 2 ns)
    always @(vclk_out) begin
        if (mon_en) begin
            if (have_last && ($realtime - last_edge) < 1.9) runts++;
            last_edge = $realtime;
            have_last = 1'b1;
        end
    end

    // 0..2 VCO, 3 external, 4 reference, 5 memory, 6 constant high
    function automatic logic exp_clk(input int idx);
        case (idx)
            0: return vco_clk[0];
            1: return vco_clk[1];
            2: return vco_clk[2];
            3: return ext_clk;
            4: return ref_clk;
            5: return mem_clk;
            default: return 1'b1;
        endcase
    endfunction

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic goto(input int t);
        while ((cyc - mark_cyc) < t) @(negedge mem_clk);
    endtask

    task automatic check_src(input int idx, input string tag, input int n);
        int mism = 0;
        repeat (n) begin
            @(posedge mem_clk);
            #0.5;
            if (vclk_out !== exp_clk(idx)) mism++;
        end
        checks++;
        if (mism != 0) begin
            errors++;
            $display("FAIL %s: %0d of %0d samples differ from source %0d (expected 0)",
                     tag, mism, n, idx);
        end
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic drive_pins(input logic e_n, input logic s1, input logic s0);
        ext_route_n = e_n; sel1_pin = s1; sel0_pin = s0;
    endtask

    task automatic set_pins(input logic e_n, input logic s1, input logic s0);
        @(posedge mem_clk); #1;
        drive_pins(e_n, s1, s0);
        mark_cyc = cyc;
    endtask

    task automatic pulse_wr(input logic [2:0] addr);
        @(posedge mem_clk); #1;
        reg_wr = 1'b1; reg_wr_addr = addr;
        mark_cyc = cyc;
        @(posedge mem_clk); #1;
        reg_wr = 1'b0;
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog: run did not complete (expected completion)");
        report();
    end

    initial begin
        repeat (10) @(posedge mem_clk);
        #1 rst_n = 1'b1;
        mark_cyc = cyc;
        mon_en = 1'b1;

        // R1: reset state
        goto(30);
        check_src(0, "R1 reset source VCO0", 12);
        check_bit(vclk_drive_en, 1'b1, "R12 drive enable at reset");

        // R2 R3 R4 R5: sel 01 -> VCO1 via reference fallback
        set_pins(1'b1, 1'b0, 1'b1);
        goto(5);            check_src(0, "R3 old clock early", 12);
        goto(T1 - 20);      check_src(0, "R3 old clock late", 12);
        goto(T1 + 40);      check_src(4, "R4 R5 reference fallback", 12);
        goto(T1 + T2 + 80); check_src(1, "R2 code 01 VCO1", 12);
        goto(T1 + T2 + 100);

        // R5 R6: doubled timeouts, memory fallback, sel 11 -> VCO2
        tmo_double = 1'b1; fb_use_mem = 1'b1;
        set_pins(1'b1, 1'b1, 1'b1);
        goto(T1 + 40);           check_src(1, "R6 doubled first timeout", 12);
        goto(2 * T1 + 50);       check_src(5, "R5 memory fallback", 12);
        goto(2 * T1 + T2 + 70);  check_src(5, "R6 doubled settle", 12);
        goto(2 * T1 + 2 * T2 + 80); check_src(2, "R2 code 11 VCO2", 12);
        goto(2 * T1 + 2 * T2 + 100);
        tmo_double = 1'b0; fb_use_mem = 1'b0;

        // R7 R2: external clock direct
        set_pins(1'b0, 1'b1, 1'b0);
        goto(5);       check_src(2, "R3 old clock before external", 12);
        goto(T1 + 40); check_src(3, "R7 external without fallback", 12);
        goto(T1 + 60);

        // R2: code 10 with routing off -> VCO2
        set_pins(1'b1, 1'b1, 1'b0);
        goto(T1 + 40);      check_src(4, "R4 fallback before VCO2", 12);
        goto(T1 + T2 + 80); check_src(2, "R2 code 10 routing off VCO2", 12);
        goto(T1 + T2 + 100);

        // R3: restart of debounce
        set_pins(1'b1, 1'b0, 1'b0);
        goto(50);
        drive_pins(1'b1, 1'b0, 1'b1);
        goto(50 + T1 - 14);      check_src(2, "R3 debounce restart", 12);
        goto(50 + T1 + T2 + 80); check_src(1, "R3 final VCO1 after restart", 12);
        goto(50 + T1 + T2 + 100);

        // R10: pins return to the active code
        set_pins(1'b1, 1'b0, 1'b0);
        goto(20);
        drive_pins(1'b1, 1'b0, 1'b1);
        goto(T1 + 40); check_src(1, "R10 pins returned", 12);
        goto(T1 + T2); check_src(1, "R10 pins returned late", 12);

        // R10: change that decodes to the same source
        set_pins(1'b0, 1'b0, 1'b1);
        goto(T1 + 40); check_src(1, "R10 same decode", 12);
        goto(T1 + 60);
        set_pins(1'b1, 1'b0, 1'b1);
        goto(T1 + 60);

        // R8: rewrite of the active VCO register
        pulse_wr(3'd1);
        goto(40);      check_src(4, "R8 active register rewrite", 12);
        goto(T2 + 80); check_src(1, "R8 back to VCO1", 12);
        goto(T2 + 100);

        // R8: rewrite of another VCO register ignored
        pulse_wr(3'd0);
        goto(40); check_src(1, "R8 other register ignored", 12);
        goto(60);

        // R8 R9: memory register rewrite, then restart during settle
        pulse_wr(3'd3);
        goto(40);  check_src(4, "R8 memory register rewrite", 12);
        goto(100);
        pulse_wr(3'd3);
        goto(90);      check_src(4, "R9 settle restarted", 12);
        goto(T2 + 80); check_src(1, "R9 back to VCO1", 12);

        // R12: output enable and power-down
        @(posedge mem_clk); #1 out_en = 1'b0;
        @(posedge mem_clk); #0.5;
        check_bit(vclk_drive_en, 1'b0, "R12 output enable low");
        #1 out_en = 1'b1;
        @(posedge mem_clk); #0.5;
        check_bit(vclk_drive_en, 1'b1, "R12 output enable high");
        mon_en = 1'b0;
        #1 pwr_dn_n = 1'b0;
        check_src(6, "R12 power-down forces high", 12);
        pwr_dn_n = 1'b1;

        // R11: glitch-free switching
        checks++;
        if (runts != 0) begin
            errors++;
            $display("FAIL R11 runt pulses: actual %0d expected 0", runts);
        end

        report();
    end

endmodule